// File: doc/BRIEF.md
# Multi-Function GPIO Controller with Interrupts

This block is a 32-pin general-purpose I/O peripheral reached over a simple register bus, one 32-bit word per register. Bit n of every register belongs to pin n. Software can read the synchronized pad levels and drive the pad output data and output enables. It also sets per-pin pull-up and drive-strength control bits, which leave the block as plain control outputs.

Each pin can hand its output and output enable to one of two alternate hardware functions. A per-pin inversion bit is applied after that choice. Each pin has four interrupt conditions: rising edge, falling edge, high level and low level. Every condition has its own enable bit and its own pending bit. Software clears a pending bit by writing one to it. Each pin drives its own interrupt line.

Alternate-function peripherals connect through plain input ports. Pad electrical behaviour is outside the block.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every writable register reads 0, every `irq` bit is 0, and `pad_oe` and `pad_out` are 0.
- R2: Registers sit at byte offsets that are multiples of 4, in this order: 0x00 input value (read-only), 0x04 input enable, 0x08 output enable, 0x0C output data, 0x10 pull-up, 0x14 drive strength, 0x18/0x1C rise enable/pending, 0x20/0x24 fall enable/pending, 0x28/0x2C high enable/pending, 0x30/0x34 low enable/pending, 0x38 function enable, 0x3C function select, 0x40 output invert. Writes to 0x00, to unmapped offsets or to unaligned addresses change nothing. Reads of unmapped or unaligned addresses return 0.
- R3: Every request cycle is answered by `bus_ready` high for exactly one cycle on the next cycle. For a read, `bus_rdata` holds the register contents as they were at the request edge.
- R4: Pad inputs pass through two flops. The value register shows the synchronized level for pins whose input enable is 1, and 0 for pins whose input enable is 0.
- R5: A rise or fall pending bit is set in the cycle after the synchronized input of an input-enabled pin changes in that direction. The enable bit has no effect on this.
- R6: A high or low pending bit is set on every cycle that an input-enabled pin's synchronized level matches. The enable bit has no effect on this.
- R7: Writing 1 to a bit of a pending register clears that bit. Writing 0 leaves the bit unchanged.
- R8: When a hardware set and a write-one clear hit the same pending bit in the same cycle, the bit ends up set.
- R9: `irq[n]` is the OR over the four conditions of (pending AND enable) for pin n.
- R10: A pin whose input enable is 0 sets no pending bit.
- R11: The selected output is the output-data and output-enable registers when the function-enable bit is 0. When it is 1, the selected output is alternate function 0 (select=0) or alternate function 1 (select=1). `pad_out` is the selected output XOR the invert bit. `pad_out` and `pad_oe` are registered, so they follow one cycle after their sources.
- R12: `pull_en` and `drive_sel` equal the pull-up and drive-strength registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access response, one cycle after the request |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| pull_en | output | 32 | Pull-up enable per pin |
| drive_sel | output | 32 | Drive strength per pin |
| alt0_out | input | 32 | Alternate function 0 output data |
| alt0_oe | input | 32 | Alternate function 0 output enable |
| alt1_out | input | 32 | Alternate function 1 output data |
| alt1_oe | input | 32 | Alternate function 1 output enable |
| irq | output | 32 | Interrupt line per pin |

## Verification
The assertions assume that every request lasts one cycle and that the bus inputs are stable around the clock edge. The bench raises `bus_req` for a single cycle per access, always on the falling edge. The assertions also assume that the alternate-function inputs change only between edges. The bench drives those inputs and `pad_in` on falling edges. It then waits enough cycles for the synchronizer and the pending stage before it reads back, so every sample falls in a settled cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NUM_KINDS = 4;
  localparam int KIND_RISE = 0;
  localparam int KIND_FALL = 1;
  localparam int KIND_HIGH = 2;
  localparam int KIND_LOW  = 3;

  localparam int OFS_VAL  = 0;
  localparam int OFS_IEN  = 1;
  localparam int OFS_OEN  = 2;
  localparam int OFS_DOUT = 3;
  localparam int OFS_PUE  = 4;
  localparam int OFS_DRV  = 5;
  localparam int OFS_IE0  = 6;   // enable of kind k at OFS_IE0 + 2k, pending at +1
  localparam int OFS_FEN  = 14;
  localparam int OFS_FSEL = 15;
  localparam int OFS_INV  = 16;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= raw_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit import gpio_pkg::*; #(
  parameter int W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [W-1:0]                level,
  input  logic [W-1:0]                in_en,
  input  logic [NUM_KINDS-1:0][W-1:0] clr,
  output logic [NUM_KINDS-1:0][W-1:0] pend
);
  logic [W-1:0]                level_prev_q;
  logic [NUM_KINDS-1:0][W-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) level_prev_q <= '0;
    else     level_prev_q <= level;
  end

  always_comb begin
    hit[KIND_RISE] = in_en &  level & ~level_prev_q;
    hit[KIND_FALL] = in_en & ~level &  level_prev_q;
    hit[KIND_HIGH] = in_en &  level;
    hit[KIND_LOW]  = in_en & ~level;
  end

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    always_ff @(posedge clk) begin
      if (rst) pend[k] <= '0;
      else     pend[k] <= (pend[k] & ~clr[k]) | hit[k];
    end

    // R8: a hardware set survives a same-cycle clear
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
      (|hit[k]) |=> ((pend[k] & $past(hit[k])) == $past(hit[k])));

    // R7: a clear without a concurrent set leaves the bit at zero
    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (rst)
      (|(clr[k] & ~hit[k])) |=> ((pend[k] & $past(clr[k] & ~hit[k])) == '0));
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sw_out,
  input  logic [W-1:0] sw_oe,
  input  logic [W-1:0] fn_en,
  input  logic [W-1:0] fn_sel,
  input  logic [W-1:0] invert,
  input  logic [W-1:0] f0_out,
  input  logic [W-1:0] f0_oe,
  input  logic [W-1:0] f1_out,
  input  logic [W-1:0] f1_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  logic [W-1:0] chosen_out, chosen_oe;

  for (genvar p = 0; p < W; p++) begin : g_pin
    always_comb begin
      if (!fn_en[p]) begin
        chosen_out[p] = sw_out[p];
        chosen_oe[p]  = sw_oe[p];
      end else if (fn_sel[p]) begin
        chosen_out[p] = f1_out[p];
        chosen_oe[p]  = f1_oe[p];
      end else begin
        chosen_out[p] = f0_out[p];
        chosen_oe[p]  = f0_oe[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= chosen_out ^ invert;
      pad_oe  <= chosen_oe;
    end
  end

  // R11: software-owned pins follow the output-enable register one cycle later
  assert_sw_oe_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_oe & ~$past(fn_en)) == ($past(sw_oe) & ~$past(fn_en))));
endmodule

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl import gpio_pkg::*; #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic              bus_ready,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pull_en,
  output logic [NPINS-1:0]  drive_sel,
  input  logic [NPINS-1:0]  alt0_out,
  input  logic [NPINS-1:0]  alt0_oe,
  input  logic [NPINS-1:0]  alt1_out,
  input  logic [NPINS-1:0]  alt1_oe,
  output logic [NPINS-1:0]  irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] reg_idx;
  logic             aligned, wr_en;
  int               idx;

  assign reg_idx = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_en   = bus_req & bus_we & aligned;
  assign idx     = int'(reg_idx);

  logic [NPINS-1:0] ien_q, oen_q, dout_q, pue_q, drv_q, fen_q, fsel_q, inv_q;
  logic [NUM_KINDS-1:0][NPINS-1:0] ie_q, pend, clr;
  logic [NPINS-1:0] sync_lvl, value;

  gpio_in_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .raw_in(pad_in), .sync_out(sync_lvl)
  );

  assign value = sync_lvl & ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= '0;
      oen_q  <= '0;
      dout_q <= '0;
      pue_q  <= '0;
      drv_q  <= '0;
      fen_q  <= '0;
      fsel_q <= '0;
      inv_q  <= '0;
    end else if (wr_en) begin
      case (idx)
        OFS_IEN:  ien_q  <= bus_wdata;
        OFS_OEN:  oen_q  <= bus_wdata;
        OFS_DOUT: dout_q <= bus_wdata;
        OFS_PUE:  pue_q  <= bus_wdata;
        OFS_DRV:  drv_q  <= bus_wdata;
        OFS_FEN:  fen_q  <= bus_wdata;
        OFS_FSEL: fsel_q <= bus_wdata;
        OFS_INV:  inv_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind_regs
    localparam int IE_OFS = OFS_IE0 + 2 * k;
    always_ff @(posedge clk) begin
      if (rst)                        ie_q[k] <= '0;
      else if (wr_en && idx == IE_OFS) ie_q[k] <= bus_wdata;
    end
    assign clr[k] = (wr_en && idx == IE_OFS + 1) ? bus_wdata : '0;
  end

  gpio_irq_unit #(.W(NPINS)) u_irq (
    .clk(clk), .rst(rst), .level(sync_lvl), .in_en(ien_q), .clr(clr), .pend(pend)
  );

  always_comb begin
    irq = '0;
    for (int k = 0; k < NUM_KINDS; k++) irq |= pend[k] & ie_q[k];
  end

  gpio_pad_mux #(.W(NPINS)) u_pad (
    .clk(clk), .rst(rst),
    .sw_out(dout_q), .sw_oe(oen_q), .fn_en(fen_q), .fn_sel(fsel_q), .invert(inv_q),
    .f0_out(alt0_out), .f0_oe(alt0_oe), .f1_out(alt1_out), .f1_oe(alt1_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign pull_en   = pue_q;
  assign drive_sel = drv_q;

  logic [NPINS-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (idx)
      OFS_VAL:  rd_mux = value;
      OFS_IEN:  rd_mux = ien_q;
      OFS_OEN:  rd_mux = oen_q;
      OFS_DOUT: rd_mux = dout_q;
      OFS_PUE:  rd_mux = pue_q;
      OFS_DRV:  rd_mux = drv_q;
      OFS_FEN:  rd_mux = fen_q;
      OFS_FSEL: rd_mux = fsel_q;
      OFS_INV:  rd_mux = inv_q;
      default: begin
        for (int k = 0; k < NUM_KINDS; k++) begin
          if (idx == OFS_IE0 + 2 * k)     rd_mux = ie_q[k];
          if (idx == OFS_IE0 + 2 * k + 1) rd_mux = pend[k];
        end
      end
    endcase
    if (!aligned) rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_ready <= 1'b0;
    end else begin
      bus_ready <= bus_req;
      if (bus_req && !bus_we) bus_rdata <= rd_mux;
    end
  end

  // R3: every request is answered on the following cycle
  assert_ready_follows_R3: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> bus_ready);
  // R3: no response without a request
  assert_no_spurious_ready_R3: assert property (@(posedge clk) disable iff (rst)
    !bus_req |=> !bus_ready);
endmodule

// File: tb/gpio_mux_ctrl_tb.sv
module gpio_mux_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst;
  logic bus_req, bus_we;
  logic [6:0] bus_addr;
  logic [N-1:0] bus_wdata, bus_rdata;
  logic bus_ready;
  logic [N-1:0] pad_in, pad_out, pad_oe, pull_en, drive_sel;
  logic [N-1:0] alt0_out, alt0_oe, alt1_out, alt1_oe, irq;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mux_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en),
    .drive_sel(drive_sel), .alt0_out(alt0_out), .alt0_oe(alt0_oe),
    .alt1_out(alt1_out), .alt1_oe(alt1_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    n_checks++;
    if (bus_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R3: ready got %b expected 1", bus_ready);
    end
    d = bus_rdata;
    @(negedge clk);
    n_checks++;
    if (bus_ready !== 1'b0) begin
      n_fail++;
      $display("FAIL R3: ready got %b expected 0 after one cycle", bus_ready);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [N-1:0] d;
    for (int a = 1; a <= 16; a++) begin
      rd(7'(a * 4), d);
      check("R1 reset register", d, '0);
    end
    check("R1 irq", irq, '0);
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_out", pad_out, '0);
  endtask

  task automatic t_regs;
    logic [N-1:0] d;
    wr(7'h08, 32'hDEAD_BEEF); rd(7'h08, d); check("R2 output enable readback", d, 32'hDEAD_BEEF);
    wr(7'h0C, 32'h1357_9BDF); rd(7'h0C, d); check("R2 output data readback", d, 32'h1357_9BDF);
    wr(7'h10, 32'hF0F0_1234); wr(7'h14, 32'h0F0F_8765);
    check("R12 pull_en", pull_en, 32'hF0F0_1234);
    check("R12 drive_sel", drive_sel, 32'h0F0F_8765);
    rd(7'h3C, d); check("R2 function select reset value", d, '0);
    wr(7'h00, 32'hFFFF_FFFF); rd(7'h00, d); check("R2 value is read-only", d, '0);
    wr(7'h44, 32'hFFFF_FFFF); rd(7'h44, d); check("R2 unmapped reads 0", d, '0);
    wr(7'h0A, 32'h0); rd(7'h08, d); check("R2 unaligned write ignored", d, 32'hDEAD_BEEF);
    rd(7'h09, d); check("R2 unaligned read 0", d, '0);
  endtask

  task automatic t_pad;
    logic [N-1:0] dout, oen, inv, fen, fsel, e_out, e_oe;
    dout = 32'hA5A5_00FF; oen = 32'hFFFF_0000; inv = 32'h0000_F00F;
    fen = 32'h0000_00F0; fsel = 32'h0000_00C0;
    alt0_out = 32'h5555_5555; alt0_oe = 32'h0000_FFFF;
    alt1_out = 32'hFFFF_FFFF; alt1_oe = 32'hFFFF_FFFF;
    wr(7'h0C, dout); wr(7'h08, oen); wr(7'h40, inv); wr(7'h3C, fsel); wr(7'h38, fen);
    wait_cyc(1);
    for (int p = 0; p < N; p++) begin
      logic so, se;
      if (!fen[p])     begin so = dout[p];     se = oen[p];     end
      else if (fsel[p]) begin so = alt1_out[p]; se = alt1_oe[p]; end
      else             begin so = alt0_out[p]; se = alt0_oe[p]; end
      e_out[p] = so ^ inv[p];
      e_oe[p] = se;
    end
    check("R11 pad_out mux and invert", pad_out, e_out);
    check("R11 pad_oe mux", pad_oe, e_oe);
  endtask

  task automatic t_input;
    logic [N-1:0] d;
    wr(7'h04, 32'h0000_00FF);
    wait_cyc(2);
    pad_in = 32'h1234_5678;
    wait_cyc(4);
    rd(7'h00, d); check("R4 value gated by input enable", d, 32'h0000_0078);
    rd(7'h1C, d); check("R5 rise pending", d, 32'h0000_0078);
    rd(7'h24, d); check("R5 fall pending none", d, '0);
    rd(7'h2C, d); check("R6 high pending / R10 disabled pins", d, 32'h0000_0078);
    rd(7'h34, d); check("R6 low pending held earlier / R10", d, 32'h0000_00FF);
  endtask

  task automatic t_fall_w1c;
    logic [N-1:0] d;
    pad_in = 32'h1234_5600;
    wait_cyc(4);
    rd(7'h24, d); check("R5 fall pending", d, 32'h0000_0078);
    wr(7'h24, 32'h0000_0008);
    rd(7'h24, d); check("R7 write one clears, zero keeps", d, 32'h0000_0070);
    wr(7'h1C, 32'hFFFF_FFFF);
    rd(7'h1C, d); check("R7 rise pending cleared", d, '0);
    wr(7'h2C, 32'hFFFF_FFFF);
    rd(7'h2C, d); check("R7 high pending cleared when low", d, '0);
  endtask

  task automatic t_set_wins;
    logic [N-1:0] d;
    wr(7'h34, 32'h0000_00FF);
    rd(7'h34, d); check("R8 low level set beats clear", d, 32'h0000_00FF);
  endtask

  task automatic t_irq;
    wr(7'h30, 32'h0000_0001);
    check("R9 irq from low enable", irq, 32'h0000_0001);
    wr(7'h20, 32'h0000_0020);
    check("R9 irq adds fall", irq, 32'h0000_0021);
    wr(7'h18, 32'h0000_0100);
    check("R9 enable without pending", irq, 32'h0000_0021);
    wr(7'h24, 32'h0000_0020);
    check("R9 irq drops after clear", irq, 32'h0000_0001);
  endtask

  initial begin
    bus_req = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0; alt0_out = '0; alt0_oe = '0; alt1_out = '0; alt1_oe = '0;
    rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    t_reset();
    t_regs();
    t_pad();
    t_input();
    t_fall_w1c();
    t_set_wins();
    t_irq();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule